// File: doc/BRIEF.md
# Dual Suffix Sequence Detector

This block watches a serial stream of single bits and raises a flag on any bit that completes one of two fixed endings: `0101` or `110`. The bits are consumed one per clock while a valid strobe is high. The flag is a Mealy output. It is high in the same cycle as the bit that completes the pattern, and it lasts one accepted bit. Only the most recent bits count. Whatever came before a pattern does not matter, and one occurrence may share bits with the next. For example, `0101` followed by `01` flags twice, and `110101` flags on its third and sixth bits.

Detection runs on a reduced six-state Mealy table. The states are named after the suffix they remember:

- `S_START`: nothing seen since reset.
- `S_0`: the stream ends in `0`.
- `S_1`: only `1` has been seen since reset.
- `S_01`: the stream ends in `01`.
- `S_11`: the stream ends in `11`.
- `S_010`: the stream ends in `010`.

The transitions are written as state, then input bit, then next state and output:

| From | On 0 | On 1 |
|---|---|---|
| `S_START` | `S_0`/0 | `S_1`/0 |
| `S_0` | `S_0`/0 | `S_01`/0 |
| `S_1` | `S_0`/0 | `S_11`/0 |
| `S_01` | `S_010`/0 | `S_11`/0 |
| `S_11` | `S_0`/1 | `S_11`/0 |
| `S_010` | `S_0`/0 | `S_01`/1 |

A parameter can add a second machine that runs alongside the first. This is the unreduced eight-state form. It has two extra states: `F_110`, which behaves like `S_0`, and `F_0101`, which behaves like `S_01`. Its flag is compared with the reduced machine's flag on every cycle.

Top module: `suffix_pair_detector`

## Requirements
- R1: While `srst_i` is high at a rising edge, the machine returns to `S_START` and forgets all earlier bits. After that edge, a lone `1` does not flag, and `1`,`1`,`0` flags on the third bit.
- R2: `hit_o` is 1, in the same cycle, on an accepted bit that makes the last four accepted bits equal `0101` (oldest first).
- R3: `hit_o` is 1, in the same cycle, on an accepted bit that makes the last three accepted bits equal `110` (oldest first).
- R4: Occurrences may overlap. Over `0101` `01` the flag is high on bits 4 and 6. Over `110101` it is high on bits 3 and 6.
- R5: On any accepted bit that completes neither pattern, `hit_o` is 0.
- R6: A cycle with `din_vld_i` low consumes no bit. `hit_o` is 0 in that cycle, and the state is unchanged whatever `din_i` holds.
- R7: `hit_o` is 0 in every cycle where `srst_i` is high, even when a valid bit completes a pattern.
- R8: When `EQUIV_CHECK` is 1, the eight-state machine and the six-state machine produce the same flag on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Serial data bit |
| din_vld_i | input | 1 | High when `din_i` carries a bit to consume |
| hit_o | output | 1 | High on the bit that completes `0101` or `110` |

## Verification
The flag is combinational from the stored state and the present input. It is due in the same cycle that a valid bit is presented, before the rising edge that absorbs that bit. The bench therefore drives each bit just after a falling edge and samples `hit_o` 1 ns later, still ahead of the next rising edge. It also checks zero-valid cycles and reset cycles at the same sampling point. It holds its own record of the last accepted bits, from which it derives the expected flag for each bit without referring to the design's state.

// File: rtl/suffix_pair_pkg.sv
package suffix_pair_pkg;

    // Reduced machine: each state is named by the suffix it remembers
    typedef enum logic [2:0] {
        S_START = 3'd0,
        S_0     = 3'd1,
        S_1     = 3'd2,
        S_01    = 3'd3,
        S_11    = 3'd4,
        S_010   = 3'd5
    } min_st_t;

    // Unreduced machine: two post-match states that the reduction merges away
    typedef enum logic [2:0] {
        F_START = 3'd0,
        F_0     = 3'd1,
        F_1     = 3'd2,
        F_01    = 3'd3,
        F_11    = 3'd4,
        F_010   = 3'd5,
        F_110   = 3'd6,
        F_0101  = 3'd7
    } full_st_t;

    localparam int unsigned LONG_PAT_LEN  = 4;
    localparam int unsigned SHORT_PAT_LEN = 3;
    localparam logic [LONG_PAT_LEN-1:0]  LONG_PAT  = 4'b0101;
    localparam logic [SHORT_PAT_LEN-1:0] SHORT_PAT = 3'b110;

endpackage

// File: rtl/suffix_min_fsm.sv
module suffix_min_fsm
    import suffix_pair_pkg::*;
(
    input  logic    clk_i,
    input  logic    srst_i,
    input  logic    step_i,
    input  logic    bit_i,
    output min_st_t state_o,
    output logic    hit_o
);

    min_st_t state_q;
    min_st_t state_d;
    logic    out_c;

    // State register
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= S_START;
        end else if (step_i) begin
            state_q <= state_d;
        end
    end

    // Next state and Mealy output
    always_comb begin
        state_d = state_q;
        out_c   = 1'b0;
        unique case (state_q)
            S_START: state_d = bit_i ? S_1  : S_0;
            S_0:     state_d = bit_i ? S_01 : S_0;
            S_1:     state_d = bit_i ? S_11 : S_0;
            S_01:    state_d = bit_i ? S_11 : S_010;
            S_11: begin
                state_d = bit_i ? S_11 : S_0;
                out_c   = !bit_i;
            end
            S_010: begin
                state_d = bit_i ? S_01 : S_0;
                out_c   = bit_i;
            end
            default: state_d = S_START;
        endcase
    end

    assign state_o = state_q;
    assign hit_o   = out_c & step_i;

endmodule

// File: rtl/suffix_full_fsm.sv
module suffix_full_fsm
    import suffix_pair_pkg::*;
(
    input  logic clk_i,
    input  logic srst_i,
    input  logic step_i,
    input  logic bit_i,
    output logic hit_o
);

    full_st_t state_q;
    full_st_t state_d;
    logic     out_c;

    // State register
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            state_q <= F_START;
        end else if (step_i) begin
            state_q <= state_d;
        end
    end

    // Next state and Mealy output, without merging equivalent states
    always_comb begin
        state_d = state_q;
        out_c   = 1'b0;
        unique case (state_q)
            F_START: state_d = bit_i ? F_1  : F_0;
            F_0:     state_d = bit_i ? F_01 : F_0;
            F_1:     state_d = bit_i ? F_11 : F_0;
            F_01:    state_d = bit_i ? F_11 : F_010;
            F_11: begin
                state_d = bit_i ? F_11 : F_110;
                out_c   = !bit_i;
            end
            F_010: begin
                state_d = bit_i ? F_0101 : F_0;
                out_c   = bit_i;
            end
            F_110:   state_d = bit_i ? F_01 : F_0;
            F_0101:  state_d = bit_i ? F_11 : F_010;
            default: state_d = F_START;
        endcase
    end

    assign hit_o = out_c & step_i;

endmodule

// File: rtl/suffix_pair_detector.sv
module suffix_pair_detector
    import suffix_pair_pkg::*;
#(
    parameter bit EQUIV_CHECK = 1'b1
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic din_i,
    input  logic din_vld_i,
    output logic hit_o
);

    logic    step;
    logic    main_hit;
    logic    ref_hit;
    min_st_t cur_st;

    // A bit is consumed only when valid and not in reset
    assign step = din_vld_i & ~srst_i;

    suffix_min_fsm u_min (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .step_i  (step),
        .bit_i   (din_i),
        .state_o (cur_st),
        .hit_o   (main_hit)
    );

    generate
        if (EQUIV_CHECK) begin : g_shadow
            suffix_full_fsm u_full (
                .clk_i  (clk_i),
                .srst_i (srst_i),
                .step_i (step),
                .bit_i  (din_i),
                .hit_o  (ref_hit)
            );
        end else begin : g_no_shadow
            assign ref_hit = main_hit;
        end
    endgenerate

    assign hit_o = main_hit;

endmodule

// File: rtl/suffix_pair_detector_chk.sv
module suffix_pair_detector_chk
    import suffix_pair_pkg::*;
(
    input logic    clk_i,
    input logic    srst_i,
    input logic    din_i,
    input logic    din_vld_i,
    input logic    hit_o,
    input min_st_t cur_st,
    input logic    ref_hit
);

    // Independent record of accepted bits since reset
    logic [2:0] hist;
    logic [1:0] seen;

    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            hist <= '0;
            seen <= '0;
        end else if (din_vld_i) begin
            hist <= {hist[1:0], din_i};
            if (seen != 2'd3) seen <= seen + 2'd1;
        end
    end

    logic long_done;
    logic short_done;
    assign long_done  = din_vld_i && (seen == 2'd3) && ({hist, din_i} == LONG_PAT);
    assign short_done = din_vld_i && (seen >= 2'd2) && ({hist[1:0], din_i} == SHORT_PAT);

    // R1: reset lands in the start state
    p_reset_start_r1: assert property (@(posedge clk_i)
        srst_i |=> (cur_st == S_START));

    // R2
    p_long_hit_r2: assert property (@(posedge clk_i) disable iff (srst_i)
        long_done |-> hit_o);

    // R3
    p_short_hit_r3: assert property (@(posedge clk_i) disable iff (srst_i)
        short_done |-> hit_o);

    // R5
    p_no_false_hit_r5: assert property (@(posedge clk_i) disable iff (srst_i)
        hit_o |-> (long_done || short_done));

    // R6
    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (srst_i)
        !din_vld_i |=> $stable(cur_st));

    // R8
    p_equiv_r8: assert property (@(posedge clk_i) disable iff (srst_i)
        hit_o == ref_hit);

endmodule

bind suffix_pair_detector suffix_pair_detector_chk u_chk (
    .clk_i     (clk_i),
    .srst_i    (srst_i),
    .din_i     (din_i),
    .din_vld_i (din_vld_i),
    .hit_o     (hit_o),
    .cur_st    (cur_st),
    .ref_hit   (ref_hit)
);

// File: tb/suffix_pair_detector_tb.sv
module suffix_pair_detector_tb;

    logic clk = 1'b0;
    logic srst_i = 1'b1;
    logic din_i = 1'b0;
    logic din_vld_i = 1'b0;
    logic hit_o;

    int checks = 0;
    int fails  = 0;

    // Bench model: last accepted bits and how many since reset
    logic [2:0] win = '0;
    int         nb  = 0;

    always #2 clk = ~clk;

    suffix_pair_detector u_dut (
        .clk_i     (clk),
        .srst_i    (srst_i),
        .din_i     (din_i),
        .din_vld_i (din_vld_i),
        .hit_o     (hit_o)
    );

    function automatic logic model_hit(logic b);
        return ((nb >= 3) && ({win, b} == 4'b0101)) ||
               ((nb >= 2) && ({win[1:0], b} == 3'b110));
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: hit_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Present one valid bit, compare with a given expectation, update the model
    task automatic send(logic b, logic exp, string req);
        @(negedge clk);
        srst_i = 1'b0; din_i = b; din_vld_i = 1'b1;
        #1 check(req, hit_o, exp);
        win = {win[1:0], b};
        nb++;
    endtask

    task automatic send_model(logic b, string req);
        send(b, model_hit(b), req);
    endtask

    task automatic idle(logic b, string req);
        @(negedge clk);
        din_i = b; din_vld_i = 1'b0;
        #1 check(req, hit_o, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        srst_i = 1'b1; din_vld_i = 1'b0;
        @(negedge clk);
        srst_i = 1'b0;
        win = '0; nb = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        #1 check("R1 reset output", hit_o, 1'b0);
        do_reset();
        send(1'b1, 1'b0, "R1 lone one after reset");
        do_reset();
        send(1'b1, 1'b0, "R1");
        send(1'b1, 1'b0, "R1");
        send(1'b0, 1'b1, "R1 110 from start");
    endtask

    task automatic t_long_pat();
        do_reset();
        send(1'b0, 1'b0, "R2"); send(1'b1, 1'b0, "R2");
        send(1'b0, 1'b0, "R2"); send(1'b1, 1'b1, "R2 0101");
    endtask

    task automatic t_short_pat();
        do_reset();
        send(1'b0, 1'b0, "R3"); send(1'b1, 1'b0, "R3");
        send(1'b1, 1'b0, "R5 011 no hit");
        send(1'b0, 1'b1, "R3 110");
    endtask

    task automatic t_overlap();
        do_reset();
        send(1'b0, 1'b0, "R4"); send(1'b1, 1'b0, "R4");
        send(1'b0, 1'b0, "R4"); send(1'b1, 1'b1, "R4 first 0101");
        send(1'b0, 1'b0, "R4"); send(1'b1, 1'b1, "R4 second 0101");
        do_reset();
        send(1'b1, 1'b0, "R4"); send(1'b1, 1'b0, "R4");
        send(1'b0, 1'b1, "R4 110"); send(1'b1, 1'b0, "R4");
        send(1'b0, 1'b0, "R4"); send(1'b1, 1'b1, "R4 0101 after 110");
    endtask

    task automatic t_idle_gap();
        do_reset();
        send(1'b0, 1'b0, "R6"); send(1'b1, 1'b0, "R6"); send(1'b0, 1'b0, "R6");
        idle(1'b1, "R6 idle one"); idle(1'b0, "R6 idle zero"); idle(1'b1, "R6 idle one");
        send(1'b1, 1'b1, "R6 0101 across gap");
        send(1'b1, 1'b0, "R6"); idle(1'b0, "R6 idle zero");
        send(1'b0, 1'b1, "R6 110 across gap");
    endtask

    task automatic t_reset_quiet();
        do_reset();
        send(1'b1, 1'b0, "R7"); send(1'b1, 1'b0, "R7");
        @(negedge clk);
        srst_i = 1'b1; din_i = 1'b0; din_vld_i = 1'b1;
        #1 check("R7 reset masks 110", hit_o, 1'b0);
        @(negedge clk);
        srst_i = 1'b0; win = '0; nb = 0;
        send(1'b0, 1'b0, "R1 history cleared");
        send(1'b1, 1'b0, "R1"); send(1'b0, 1'b0, "R1");
        send(1'b1, 1'b1, "R2 after reset");
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic b;
            b = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) idle(b, "R6 random idle");
            else send_model(b, "R5 random stream");
        end
    endtask

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        t_reset_state();
        t_long_pat();
        t_short_pat();
        t_overlap();
        t_idle_gap();
        t_reset_quiet();
        t_random();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule